// File: doc/BRIEF.md
# Saturating Lane Absolute/Negate Unit

This unit treats a 64-bit input word as a packed vector of signed lanes and produces, for every lane, either its saturating absolute value or its saturating negation. Plain two's complement arithmetic cannot represent the magnitude of the most-negative lane value. Instead of wrapping, the unit clamps that lane to the most-positive value and records the event in a cumulative saturation flag.

The datapath is purely combinational. A lane width code selects 8, 16, 32 or 64-bit lanes, and a lane count limits how many lanes, counted up from bit 0, take part in the operation. The only storage is the flag. Once a valid operation has saturated, the flag stays set until an explicit clear. Software can therefore run a long stream of operations and test for any overflow once at the end.

Top module: `sat_absneg_unit`

## Requirements
- R1: `neg_mode` = 1 selects negation for every active lane, and `neg_mode` = 0 selects absolute value.
- R2: An active lane that holds only its sign bit set outputs all ones except the sign bit, in both modes. After a valid operation, the flag is set at the next clock edge.
- R3: In absolute mode, an active negative lane that is not the most-negative value outputs its two's complement negation.
- R4: In absolute mode, an active non-negative lane passes through unchanged and does not set the flag.
- R5: In negate mode, every active lane that is not the most-negative value outputs its two's complement negation, including zero (which gives zero) and positive values.
- R6: `width_sel` codes 0, 1, 2 and 3 select lane widths of 8, 16, 32 and 64 bits. Lane i of width w occupies bits [i*w +: w].
- R7: Lanes with index at or above `lane_count`, or beyond the number that fits in 64 bits, output zero and never set the flag.
- R8: The flag is sticky. Once set, it stays set across later operations until it is cleared.
- R9: `sat_clr` clears the flag at the next edge. If a valid saturating operation occurs in the same cycle, the flag is set instead.
- R10: With `op_valid` low, the flag keeps its value, while `dout` still shows the combinational result.
- R11: While `rst_n` is low, the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Current operation counts toward the flag |
| neg_mode | input | 1 | 1 = negate, 0 = absolute value |
| width_sel | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64) |
| lane_count | input | 4 | Number of active lanes from bit 0 |
| din | input | 64 | Packed signed lanes |
| sat_clr | input | 1 | Clears the saturation flag |
| dout | output | 64 | Packed result lanes |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The vectors cover all-positive and all-negative byte lanes in absolute mode, which tells passthrough apart from negation. A mixed vector containing zero in negate mode shows that non-negative lanes are negated only under that mode. Each lane width is exercised with patterns whose lanes differ, so a wrong lane boundary or carry between lanes shows up. Most-negative values are placed in active lanes, in inactive lanes and in operations with the valid input low, which separates clamping from flag accounting. Clear is tried both alone and together with a saturating operation to pin down which one takes priority.

// File: rtl/sat_absneg_unit.sv
module sat_absneg_unit #(
  parameter int DATA_W = 64,
  parameter int MIN_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              neg_mode,
  input  logic [1:0]        width_sel,
  input  logic [CNT_W-1:0]  lane_count,
  input  logic [DATA_W-1:0] din,
  input  logic              sat_clr,
  output logic [DATA_W-1:0] dout,
  output logic              sat_flag
);
  localparam int NUM_WIDTHS = 4;

  logic [DATA_W-1:0] res_by_w [NUM_WIDTHS];
  logic [NUM_WIDTHS-1:0] sat_by_w;
  logic ovf;

  for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
    localparam int W = MIN_W << k;
    localparam int N = DATA_W / W;
    logic [DATA_W-1:0] res;
    logic [N-1:0]      lane_sat;

    for (genvar i = 0; i < N; i++) begin : g_lane
      logic [W-1:0] x, y;
      logic is_min, act;
      assign x      = din[i*W +: W];
      assign is_min = (x == {1'b1, {(W-1){1'b0}}});
      assign act    = (lane_count > CNT_W'(i));
      assign y      = is_min ? {1'b0, {(W-1){1'b1}}}
                    : (neg_mode | x[W-1]) ? (~x + 1'b1) : x;
      assign res[i*W +: W] = act ? y : '0;
      assign lane_sat[i]   = act & is_min;
    end

    if (N * W < DATA_W) begin : g_pad
      assign res[DATA_W-1:N*W] = '0;
    end

    assign res_by_w[k] = res;
    assign sat_by_w[k] = |lane_sat;
  end

  assign dout = res_by_w[width_sel];
  assign ovf  = sat_by_w[width_sel];

  always_ff @(posedge clk) begin
    if (!rst_n)
      sat_flag <= 1'b0;
    else if (sat_clr || (op_valid && ovf))
      sat_flag <= op_valid && ovf;
  end
endmodule

// File: rtl/sat_absneg_unit_chk.sv
module sat_absneg_unit_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              neg_mode,
  input logic [1:0]        width_sel,
  input logic [CNT_W-1:0]  lane_count,
  input logic [DATA_W-1:0] dout,
  input logic              sat_clr,
  input logic              sat_flag
);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clr |=> sat_flag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr && !op_valid |=> !sat_flag);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && !sat_clr |=> $stable(sat_flag));

  assert_rise_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> $past(op_valid));

  assert_no_active_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lane_count == '0 |-> dout == '0);

  assert_abs_not_negative_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !neg_mode && width_sel == 2'd3 && lane_count != '0 |-> !dout[DATA_W-1]);
endmodule

bind sat_absneg_unit sat_absneg_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .neg_mode(neg_mode),
  .width_sel(width_sel), .lane_count(lane_count), .dout(dout),
  .sat_clr(sat_clr), .sat_flag(sat_flag)
);

// File: tb/sat_absneg_unit_test.sv
module sat_absneg_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        op_valid = 0, neg_mode = 0, sat_clr = 0;
  logic [1:0]  width_sel = 0;
  logic [3:0]  lane_count = 0;
  logic [63:0] din = 0;
  logic [63:0] dout;
  logic        sat_flag;

  int checks = 0, errors = 0;
  logic mflag = 0;

  always #5 clk = ~clk;

  sat_absneg_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .neg_mode(neg_mode),
    .width_sel(width_sel), .lane_count(lane_count), .din(din),
    .sat_clr(sat_clr), .dout(dout), .sat_flag(sat_flag)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic nm, input logic [1:0] ws, input logic [3:0] cnt,
                       input logic [63:0] d, output logic [63:0] r, output logic o);
    int w = 8 << ws;
    int n = 64 / w;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [63:0] minv = 64'd1 << (w - 1);
    r = '0; o = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] v, y;
      if (i >= int'(cnt)) continue;
      v = (d >> (i * w)) & mask;
      if (v == minv) begin y = minv - 1; o = 1'b1; end
      else if (nm || v[w-1]) y = (~v + 1) & mask;
      else y = v;
      r = r | (y << (i * w));
    end
  endtask

  task automatic step(input logic v, input logic nm, input logic [1:0] ws,
                      input logic [3:0] cnt, input logic [63:0] d,
                      input logic clr, input string tag);
    logic [63:0] er;
    logic eo;
    @(negedge clk);
    chk({63'd0, sat_flag}, {63'd0, mflag}, {tag, " flag before"});
    op_valid = v; neg_mode = nm; width_sel = ws; lane_count = cnt; din = d; sat_clr = clr;
    #1;
    model(nm, ws, cnt, d, er, eo);
    chk(dout, er, {tag, " result"});
    @(posedge clk);
    if (clr || (v && eo)) mflag = v && eo;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({63'd0, sat_flag}, 64'd0, "R11 reset flag");
    chk(dout, 64'd0, "R11 reset result");
    rst_n = 1;
    step(1, 0, 0, 8, 64'h7F01_0040_1020_3005, 0, "R4 abs byte positives");
    step(1, 0, 0, 8, 64'hFFFE_81C0_90A0_F0F1, 0, "R3 abs byte negatives");
    step(1, 1, 0, 8, 64'h0001_7FFF_4010_C3FE, 0, "R5 R1 neg byte mixed");
    step(1, 1, 1, 4, 64'h0000_7FFF_1234_FFFF, 0, "R6 neg halfword");
    step(1, 0, 2, 2, 64'hFFFF_FFFE_0012_3456, 0, "R6 abs word");
    step(1, 0, 3, 1, 64'hFFFF_FFFF_0000_0001, 0, "R6 abs dword");
    step(1, 0, 0, 3, 64'h0000_8000_00FF_0102, 0, "R7 inactive min no flag");
    step(1, 1, 0, 0, 64'h8080_8080_8080_8080, 0, "R7 zero lanes");
    step(1, 0, 3, 8, 64'h1234_5678_9ABC_DEF0, 0, "R7 dword beyond capacity");
    step(0, 0, 0, 8, 64'h8011_2233_4455_6680, 0, "R10 invalid min");
    step(1, 0, 1, 4, 64'h0001_8000_0002_0003, 0, "R2 halfword min");
    step(1, 1, 0, 8, 64'h0102_0304_0506_0708, 0, "R8 sticky");
    step(0, 0, 0, 8, 64'h0, 0, "R8 R10 idle hold");
    step(1, 0, 0, 8, 64'h0102_0304_0506_0708, 1, "R9 clear");
    step(1, 1, 3, 1, 64'h8000_0000_0000_0000, 1, "R9 R2 clear with saturation");
    step(1, 1, 2, 1, 64'h8000_0000_8000_0000, 0, "R2 R7 word min lane0");
    step(0, 0, 0, 8, 64'h0, 1, "R9 plain clear");
    step(0, 1, 2, 2, 64'h0000_0005_FFFF_FFFB, 0, "R5 neg word");
    @(negedge clk);
    chk({63'd0, sat_flag}, {63'd0, mflag}, "R9 final flag");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule